// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo audio from a three-wire serial link (a word-select line that marks the channel, a bit clock, and one data line) and turns it into parallel 24-bit sample words. All three lines are sampled in the core clock domain. The core clock must run well above the bit clock. The lines pass through a small synchronizer, and the bit clock's rising edges are found inside the block. Data is taken on those rising edges and is sent MSB first. A change in the word-select level between two successive rising edges marks the boundary between channel halves. Each word-select period carries one left word and one right word.

A two-bit format input picks one of four framings. Code 00 is the standard I2S framing: the MSB comes one bit clock after the channel edge, and a low word-select means left. Code 01 is left-justified: the MSB comes on the edge itself, and a high word-select means left. Codes 10 and 11 are right-justified with 24-bit and 16-bit words, again with high meaning left. In these two the word ends on the last bit clock before the channel edge. The format is taken at each channel edge, so a change on the input affects only the next half.

Each completed half is reported after the channel edge that closes it, as a one-cycle valid pulse together with a left/right tag and the 24-bit word. The half that is in progress when reset is released is never reported.

Top module: `serial_audio_rx`

## Requirements
- R1: With format 00 (I2S), the bit sampled on the first bit-clock rising edge after a word-select change is ignored. The next 24 bits form the word, MSB first, and the word is tagged left when word-select was low during that half.
- R2: With format 01 (left-justified), the bit sampled on the rising edge where the word-select change is seen is the MSB of a 24-bit word, and the word is tagged left when word-select was high.
- R3: With format 10 (right-justified, 24-bit), the word is the last 24 bits sampled before the rising edge on which the change is seen. Earlier bits of that half are ignored. The tag follows R2's polarity.
- R4: With format 11 (right-justified, 16-bit), the word is the last 16 bits before the change, sign-extended into bits 23..16. The tag follows R2's polarity.
- R5: In formats 00 and 01, bits after the 24th data bit of a half are ignored. A half that carries fewer data bits gives a word aligned to bit 23, with the missing low bits set to zero.
- R6: Each completed half produces exactly one valid pulse, one core clock wide, with the tag and the word. The pulse follows the bit-clock rising edge on which the word-select change is seen.
- R7: The half that is in progress when reset is released produces no valid pulse. Reporting starts with the first half that begins after reset.
- R8: A change on the format input takes effect at the next word-select change. The half already in progress is decoded with the format it started with.
- R9: While reset is asserted, valid is low, the tag is low and the word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified 24-bit, 11 right-justified 16-bit |
| sclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word select (channel frame clock) |
| sdin | input | 1 | Serial data, MSB first |
| smp_valid | output | 1 | One-cycle strobe for a completed channel word |
| smp_left | output | 1 | High when the word belongs to the left channel |
| smp_data | output | 24 | Received word, aligned to bit 23 |

## Verification
The assertions assume the bit clock is slow enough that two of its rising edges never fall on consecutive core clocks. They also assume that word-select and data change only away from the bit clock's rising edge, so that all three synchronized lines agree on the edge where they are sampled. The stimulus holds each bit-clock phase for four core clocks. It changes word-select and data together with the falling bit-clock edge and keeps each run between resets. Each run opens with a partial half so that the R7 case is exercised on every run.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ16 = 2'b11
  } sarx_fmt_e;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q[g] <= '0;
        else if (g == 0) st_q[g] <= d;
        else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/sarx_front.sv
module sarx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic lrck,
  input  logic sdin,
  output logic bit_stb,
  output logic bit_sd,
  output logic lr_edge,
  output logic lr_prev
);
  logic [2:0] raw, syn;
  logic       s_sclk, s_lr;
  logic       sclk_dq, lr_prev_q, primed_q;
  logic       lr_prev_d, primed_d;

  assign raw = {sclk, lrck, sdin};

  sarx_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign s_sclk  = syn[2];
  assign s_lr    = syn[1];
  assign bit_sd  = syn[0];
  assign bit_stb = s_sclk & ~sclk_dq;
  assign lr_edge = bit_stb & primed_q & (s_lr != lr_prev_q);
  assign lr_prev = lr_prev_q;

  always_comb begin
    lr_prev_d = lr_prev_q;
    primed_d  = primed_q;
    if (bit_stb) begin
      lr_prev_d = s_lr;
      primed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_dq   <= 1'b0;
      lr_prev_q <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      sclk_dq   <= s_sclk;
      lr_prev_q <= lr_prev_d;
      primed_q  <= primed_d;
    end
  end
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_sd,
  input  logic              lr_edge,
  input  sarx_fmt_e         fmt_cur,
  output logic [WORD_W-1:0] cap,
  output logic [WORD_W-1:0] tail
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, idx;
  logic [WORD_W-1:0] cap_q, cap_d, tail_q, tail_d;

  always_comb begin
    cnt_d  = cnt_q;
    cap_d  = cap_q;
    tail_d = tail_q;
    idx    = lr_edge ? '0 : cnt_q;
    if (bit_stb) begin
      tail_d = {tail_q[WORD_W-2:0], bit_sd};
      if (lr_edge) begin
        cap_d = '0;
        cnt_d = CNT_W'(1);
      end else if (cnt_q != SAT) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      for (int k = 0; k < WORD_W; k++) begin
        if ((fmt_cur == FMT_I2S && idx == CNT_W'(k + 1)) ||
            (fmt_cur == FMT_LJ  && idx == CNT_W'(k)))
          cap_d[WORD_W-1-k] = bit_sd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= SAT;
      cap_q  <= '0;
      tail_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      tail_q <= tail_d;
    end
  end

  assign cap  = cap_q;
  assign tail = tail_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              sclk,
  input  logic              lrck,
  input  logic              sdin,
  output logic              smp_valid,
  output logic              smp_left,
  output logic [WORD_W-1:0] smp_data
);
  localparam int EXT_W = WORD_W - SHORT_W;

  logic              bit_stb, bit_sd, lr_edge, lr_prev;
  logic [WORD_W-1:0] cap, tail, word;
  sarx_fmt_e         fmt_act_q, fmt_act_d, fmt_cur, ofmt_q, ofmt_d;
  logic              armed_q, armed_d, vld_q, vld_d, left_q, left_d, emit;
  logic [WORD_W-1:0] data_q, data_d;

  sarx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrck(lrck), .sdin(sdin),
    .bit_stb(bit_stb), .bit_sd(bit_sd), .lr_edge(lr_edge), .lr_prev(lr_prev)
  );

  assign fmt_cur = lr_edge ? sarx_fmt_e'(fmt_sel) : fmt_act_q;

  sarx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_sd(bit_sd),
    .lr_edge(lr_edge), .fmt_cur(fmt_cur), .cap(cap), .tail(tail)
  );

  always_comb begin
    unique case (fmt_act_q)
      FMT_I2S, FMT_LJ: word = cap;
      FMT_RJ24:        word = tail;
      default:         word = {{EXT_W{tail[SHORT_W-1]}}, tail[SHORT_W-1:0]};
    endcase
  end

  assign emit = lr_edge & armed_q;

  always_comb begin
    fmt_act_d = lr_edge ? sarx_fmt_e'(fmt_sel) : fmt_act_q;
    armed_d   = armed_q | lr_edge;
    vld_d     = emit;
    left_d    = left_q;
    data_d    = data_q;
    ofmt_d    = ofmt_q;
    if (emit) begin
      left_d = (fmt_act_q == FMT_I2S) ? ~lr_prev : lr_prev;
      data_d = word;
      ofmt_d = fmt_act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act_q <= FMT_I2S;
      armed_q   <= 1'b0;
      vld_q     <= 1'b0;
      left_q    <= 1'b0;
      data_q    <= '0;
      ofmt_q    <= FMT_I2S;
    end else begin
      fmt_act_q <= fmt_act_d;
      armed_q   <= armed_d;
      vld_q     <= vld_d;
      left_q    <= left_d;
      data_q    <= data_d;
      ofmt_q    <= ofmt_d;
    end
  end

  assign smp_valid = vld_q;
  assign smp_left  = left_q;
  assign smp_data  = data_q;
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [WORD_W-1:0] smp_data,
  input logic [1:0]        ofmt_q,
  input logic [1:0]        fmt_act_q,
  input logic              lr_edge,
  input logic              armed_q,
  input logic              bit_stb
);
  localparam int EXT_W = WORD_W - SHORT_W;

  // R6: the strobe lasts a single core clock
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R6: a strobe always follows a bit-clock rising edge
  p_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(bit_stb));

  // R7: nothing is reported before the first boundary after reset
  p_armed_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(armed_q));

  // R8: the active format moves only on a channel boundary
  p_fmt_at_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_act_q != $past(fmt_act_q)) |-> $past(lr_edge));

  // R4: short right-justified words are sign-extended
  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ofmt_q == 2'b11) |->
      (smp_data[WORD_W-1:SHORT_W] == {EXT_W{smp_data[SHORT_W-1]}}));
endmodule

bind serial_audio_rx sarx_checker #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .ofmt_q(ofmt_q), .fmt_act_q(fmt_act_q), .lr_edge(lr_edge),
  .armed_q(armed_q), .bit_stb(bit_stb)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic        clk, rst_n, sclk, lrck, sdin;
  logic [1:0]  fmt_sel;
  logic        smp_valid, smp_left;
  logic [23:0] smp_data;

  int          errors = 0;
  int          checks = 0;
  int          npulse = 0;
  logic [23:0] got_d [8];
  logic        got_l [8];

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sclk(sclk), .lrck(lrck),
    .sdin(sdin), .smp_valid(smp_valid), .smp_left(smp_left), .smp_data(smp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && smp_valid && npulse < 8) begin
      got_d[npulse] = smp_data;
      got_l[npulse] = smp_left;
      npulse++;
    end
  end

  task automatic check(input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] f);
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdin = 1'b0; fmt_sel = f;
    repeat (3) @(negedge clk);
    npulse = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic lr, input logic [31:0] vec, input int n,
                      input int sw_at, input logic [1:0] sw_fmt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk = 1'b0; lrck = lr; sdin = vec[n-1-i];
      if (i == sw_at) fmt_sel = sw_fmt;
      repeat (HALF_SCLK) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF_SCLK - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    @(negedge clk); sclk = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_two(input string tag, input logic [23:0] d0, input logic l0,
                            input logic [23:0] d1, input logic l1);
    check({tag, " pulse count"}, 25'(npulse), 25'd2);
    check({tag, " first word"}, {got_l[0], got_d[0]}, {l0, d0});
    check({tag, " second word"}, {got_l[1], got_d[1]}, {l1, d1});
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = 2'b00; sclk = 1'b0; lrck = 1'b0; sdin = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 valid in reset", 25'(smp_valid), 25'd0);
    check("R9 tag and word in reset", {smp_left, smp_data}, 25'd0);
  endtask

  // R1 R6 R7: I2S, low = left, first bit after the boundary skipped
  task automatic t_i2s;
    do_reset(2'b00);
    send(1'b1, 32'hFFFF_FFFF, 5, -1, 2'b00);
    send(1'b0, {1'b1, 24'hA5C3_19, 7'h7F}, 32, -1, 2'b00);
    send(1'b1, {1'b1, 24'h5E_0F12, 7'h55}, 32, -1, 2'b00);
    send(1'b0, 32'hFFFF_FFFF, 4, -1, 2'b00);
    finish_run();
    expect_two("R1 R6 R7 i2s", 24'hA5C319, 1'b1, 24'h5E0F12, 1'b0);
  endtask

  // R2 R5: left-justified, trailing bits ignored
  task automatic t_lj;
    do_reset(2'b01);
    send(1'b0, 32'h0, 3, -1, 2'b01);
    send(1'b1, {24'h81_2345, 8'hFF}, 32, -1, 2'b01);
    send(1'b0, {24'h7E_DCBA, 8'hA5}, 32, -1, 2'b01);
    send(1'b1, 32'hFFFF_FFFF, 3, -1, 2'b01);
    finish_run();
    expect_two("R2 R5 left-justified", 24'h812345, 1'b1, 24'h7EDCBA, 1'b0);
  endtask

  // R3: right-justified 24-bit, leading bits ignored
  task automatic t_rj24;
    do_reset(2'b10);
    send(1'b0, 32'hFFFF_FFFF, 3, -1, 2'b10);
    send(1'b1, {8'hFF, 24'h13_579B}, 32, -1, 2'b10);
    send(1'b0, {8'h3C, 24'hF0_0F0F}, 32, -1, 2'b10);
    send(1'b1, 32'h0, 3, -1, 2'b10);
    finish_run();
    expect_two("R3 right-justified 24", 24'h13579B, 1'b1, 24'hF00F0F, 1'b0);
  endtask

  // R4: right-justified 16-bit, sign-extended
  task automatic t_rj16;
    do_reset(2'b11);
    send(1'b0, 32'h0, 3, -1, 2'b11);
    send(1'b1, {16'h0000, 16'h8123}, 32, -1, 2'b11);
    send(1'b0, {16'hFFFF, 16'h1234}, 32, -1, 2'b11);
    send(1'b1, 32'h0, 3, -1, 2'b11);
    finish_run();
    expect_two("R4 right-justified 16", 24'hFF8123, 1'b1, 24'h001234, 1'b0);
  endtask

  // R5: short left-justified words zero-filled below
  task automatic t_short;
    do_reset(2'b01);
    send(1'b0, 32'h0, 3, -1, 2'b01);
    send(1'b1, {16'h0, 16'hBEEF}, 16, -1, 2'b01);
    send(1'b0, {16'h0, 16'h0001}, 16, -1, 2'b01);
    send(1'b1, 32'hFFFF_FFFF, 3, -1, 2'b01);
    finish_run();
    expect_two("R5 short words", 24'hBEEF00, 1'b1, 24'h000100, 1'b0);
  endtask

  // R8: format change mid-half applies from the next boundary
  task automatic t_switch;
    do_reset(2'b01);
    send(1'b0, 32'h0, 3, -1, 2'b01);
    send(1'b1, {24'hC0_FFEE, 8'h00}, 32, 10, 2'b10);
    send(1'b0, {8'hFF, 24'h0A_0B0C}, 32, -1, 2'b10);
    send(1'b1, 32'h0, 3, -1, 2'b10);
    finish_run();
    expect_two("R8 format switch", 24'hC0FFEE, 1'b1, 24'h0A0B0C, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdin = 1'b0; fmt_sel = 2'b00;
    t_reset();
    t_i2s();
    t_lj();
    t_rj24();
    t_rj16();
    t_short();
    t_switch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule